// File: doc/BRIEF.md
# Burst Address and Command Sequencer

This block sits between the synchronous control pins of a burst-capable static RAM and its internal datapath. At every rising clock edge it classifies the control inputs into one cycle type: deselect, begin (read or write), continue burst or suspend burst. It then updates a small address state. Two active-low address strobes compete to start a cycle. The processor strobe is masked by the first chip enable and always starts a read. The controller strobe starts a read or a write, as the write controls decide.

On a begin cycle the external address is captured. After that, only the two low address bits move. They are stepped by a 2-bit burst counter that runs either in linear order or in XOR-style interleaved order, chosen by a static order input. The datapath receives the effective address, a registered command, a per-byte write mask and a flag showing that a burst is open.

A sleep input takes effect two clocks after it rises. From then on the block behaves as deselected and keeps its address state. When sleep ends, a recovery window of a parameterised length follows. During that window a write is refused and flagged instead of being carried out.

Top module: `burst_seq`

## Requirements
- R1: With `order_ilv` low (linear order), each continue cycle adds one to the low two address bits modulo 4, starting from the captured start value.
- R2: With `order_ilv` high (interleaved order), the low two address bits on the n-th access of a burst equal the start value XOR (n-1 mod 4).
- R3: On the fifth access of a burst the address returns to the start value captured by the begin cycle, in both orders.
- R4: A begin cycle from the processor strobe (low, with `ce1_n` low and the chip enabled) is a read (`cmd_o` = 01) and has an all-zero write mask, whatever the write inputs are.
- R5: A begin from the controller strobe (processor strobe not effective) is a write (`cmd_o` = 10) when `wr_all_n` is low, with every mask bit set. It is also a write when `wr_byte_n` is low and at least one `byte_en_n` bit is low, with mask bit i set exactly when `byte_en_n[i]` is low. Otherwise it is a read with a zero mask.
- R6: With `ce1_n` high the processor strobe is ignored. If the controller strobe is also high, the cycle is handled as if neither strobe were present.
- R7: With both strobes ineffective during an open burst, `adv_n` low steps the counter and `adv_n` high holds the address. The command type comes from the write inputs as in R5. The address bits above bit 1 never change within a burst.
- R8: The cycle is a deselect (`cmd_o` = 00, `active_o` cleared) in three cases: the controller strobe is low with `ce1_n` high; a strobe is effective while `ce2` is low or `ce3_n` is high; or no burst is open and no strobe is effective.
- R9: Two edges after `sleep_i` is sampled high, every cycle is a deselect and all other inputs are ignored; `addr_o` keeps its value.
- R10: For `RECOV_CYC` cycles after the block leaves sleep, any write is not executed: `cmd_o` is 00, the address state is held and `err_o` is 1 for that cycle. Reads are executed normally.
- R11: After reset, `cmd_o` is 00, `active_o` is 0, `err_o` is 0 and `wr_mask_o` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sleep_i | input | 1 | Sleep request, active high |
| order_ilv | input | 1 | Burst order: 1 interleaved, 0 linear |
| ads_proc_n | input | 1 | Processor address strobe, active low |
| ads_ctrl_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce1_n | input | 1 | Chip enable 1, active low; masks the processor strobe |
| ce2 | input | 1 | Chip enable 2, active high, sampled with a strobe |
| ce3_n | input | 1 | Chip enable 3, active low, sampled with a strobe |
| wr_all_n | input | 1 | Write all bytes, active low |
| wr_byte_n | input | 1 | Byte write qualifier, active low |
| byte_en_n | input | NB | Per-byte write selects, active low |
| addr_i | input | AW | External address |
| addr_o | output | AW | Effective address of the current cycle |
| cmd_o | output | 2 | Registered command: 00 idle, 01 read, 10 write |
| wr_mask_o | output | NB | Bytes to write in the current cycle |
| active_o | output | 1 | A burst is open |
| err_o | output | 1 | A write was refused during recovery |

## Verification
The embedded properties check these rules on every cycle: sleep forces an idle command, a refused write leaves the command idle, the write mask is zero unless the command is a write, and a plain idle clears the burst flag. They also check that the counter holds its address when neither loading nor stepping, that the upper bits do not change while stepping, and that a load takes the external address. The bench alone can show the full visiting order of both counter modes from every start value and the return to the start value on the fifth access. It also covers the priority between the two strobes under every enable pattern, the complete byte-mask decode, and the exact edges at which sleep takes hold and the recovery window closes.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
   typedef enum logic [1:0] {
      CMD_IDLE  = 2'b00,
      CMD_READ  = 2'b01,
      CMD_WRITE = 2'b10
   } cmd_e;

   typedef enum logic [2:0] {
      K_DESEL,
      K_BEGIN,
      K_CONT,
      K_HOLD,
      K_NOP
   } kind_e;
endpackage

// File: rtl/burst_cmd_decode.sv
module burst_cmd_decode
   import burst_seq_pkg::*;
#(
   parameter int NB = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          asleep,
   input  logic          recovering,
   input  logic          burst_live,
   input  logic          ads_proc_n,
   input  logic          ads_ctrl_n,
   input  logic          adv_n,
   input  logic          ce1_n,
   input  logic          ce2,
   input  logic          ce3_n,
   input  logic          wr_all_n,
   input  logic          wr_byte_n,
   input  logic [NB-1:0] byte_en_n,
   output kind_e         kind,
   output logic          is_wr,
   output logic          illegal,
   output logic [NB-1:0] lane_mask
);
   logic enabled, p_go, any_lane, wr_want;

   assign enabled  = ce2 && !ce3_n;
   assign p_go     = !ads_proc_n && !ce1_n;
   assign any_lane = |(~byte_en_n);
   assign wr_want  = !wr_all_n || (!wr_byte_n && any_lane);

   for (genvar g = 0; g < NB; g++) begin : g_lane
      assign lane_mask[g] = !wr_all_n || (!wr_byte_n && !byte_en_n[g]);
   end

   always_comb begin
      kind    = K_DESEL;
      is_wr   = 1'b0;
      illegal = 1'b0;
      if (!asleep) begin
         if (p_go) begin
            if (enabled) kind = K_BEGIN;
         end else if (!ads_ctrl_n) begin
            if (!ce1_n && enabled) begin
               kind  = K_BEGIN;
               is_wr = wr_want;
            end
         end else if (burst_live) begin
            kind  = adv_n ? K_HOLD : K_CONT;
            is_wr = wr_want;
         end
         if (recovering && is_wr) begin
            kind    = K_NOP;
            is_wr   = 1'b0;
            illegal = 1'b1;
         end
      end
   end

   // R4: an effective processor strobe never yields a write
   p_proc_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!asleep && p_go) |-> !is_wr);
   // R9: sleeping forces a deselect
   p_sleep_desel_r9: assert property (@(posedge clk) disable iff (!rst_n)
      asleep |-> (kind == K_DESEL));
endmodule

// File: rtl/burst_addr_ctr.sv
module burst_addr_ctr #(
   parameter int AW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          step,
   input  logic          order_ilv,
   input  logic [AW-1:0] addr_i,
   output logic [AW-1:0] addr_o
);
   localparam int HI = AW - 2;

   logic [AW-1:0] base_q;
   logic [1:0]    k_q;
   logic [1:0]    lo;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q <= '0;
         k_q    <= 2'd0;
      end else if (load) begin
         base_q <= addr_i;
         k_q    <= 2'd0;
      end else if (step) begin
         k_q    <= k_q + 2'd1;
      end
   end

   assign lo     = order_ilv ? (base_q[1:0] ^ k_q) : (base_q[1:0] + k_q);
   assign addr_o = {base_q[AW-1:2], lo};

   // R7: no load and no step keeps the address (order held fixed)
   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !step) |=> (!$stable(order_ilv) || $stable(addr_o)));
   // R7: stepping never touches the upper bits
   p_upper_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load) |=> $stable(addr_o[AW-1:2]));
   // R3: a load presents the external address as the first access
   p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (addr_o == $past(addr_i)));
   // R7: a step always changes the low bits
   p_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load) |=> (!$stable(order_ilv) || (addr_o[1:0] != $past(addr_o[1:0]))));
   initial assert (HI >= 1);
endmodule

// File: rtl/burst_sleep_ctl.sv
module burst_sleep_ctl #(
   parameter int RECOV_CYC = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sleep_i,
   output logic asleep,
   output logic recovering
);
   localparam int RW = $clog2(RECOV_CYC + 1);

   logic          sz1_q, sz2_q;
   logic [RW-1:0] rec_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sz1_q <= 1'b0;
         sz2_q <= 1'b0;
         rec_q <= '0;
      end else begin
         sz1_q <= sleep_i;
         sz2_q <= sz1_q;
         if (sz2_q && !sz1_q)      rec_q <= RW'(RECOV_CYC);
         else if (rec_q != '0)     rec_q <= rec_q - RW'(1);
      end
   end

   assign asleep     = sz2_q;
   assign recovering = (rec_q != '0);

   // R10: leaving sleep opens the recovery window at once
   p_wake_recov_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(asleep) |-> recovering);
   // R9: sleep takes hold only after a request was seen
   p_sleep_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(asleep) |-> $past(sz1_q));
endmodule

// File: rtl/burst_seq.sv
module burst_seq
   import burst_seq_pkg::*;
#(
   parameter int AW        = 8,
   parameter int NB        = 2,
   parameter int RECOV_CYC = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sleep_i,
   input  logic          order_ilv,
   input  logic          ads_proc_n,
   input  logic          ads_ctrl_n,
   input  logic          adv_n,
   input  logic          ce1_n,
   input  logic          ce2,
   input  logic          ce3_n,
   input  logic          wr_all_n,
   input  logic          wr_byte_n,
   input  logic [NB-1:0] byte_en_n,
   input  logic [AW-1:0] addr_i,
   output logic [AW-1:0] addr_o,
   output logic [1:0]    cmd_o,
   output logic [NB-1:0] wr_mask_o,
   output logic          active_o,
   output logic          err_o
);
   if (AW < 3) begin : g_bad_aw
      $error("burst_seq: AW must be at least 3");
   end
   if (NB < 1) begin : g_bad_nb
      $error("burst_seq: NB must be at least 1");
   end
   if (RECOV_CYC < 1) begin : g_bad_rec
      $error("burst_seq: RECOV_CYC must be at least 1");
   end

   logic          asleep, recovering, is_wr, illegal;
   kind_e         kind;
   logic [NB-1:0] lane_mask;
   cmd_e          cmd_q;
   logic [NB-1:0] mask_q;
   logic          live_q, err_q;
   logic          moves;

   burst_sleep_ctl #(.RECOV_CYC(RECOV_CYC)) u_sleep (
      .clk(clk), .rst_n(rst_n), .sleep_i(sleep_i),
      .asleep(asleep), .recovering(recovering)
   );

   burst_cmd_decode #(.NB(NB)) u_dec (
      .clk(clk), .rst_n(rst_n), .asleep(asleep), .recovering(recovering),
      .burst_live(live_q), .ads_proc_n(ads_proc_n), .ads_ctrl_n(ads_ctrl_n),
      .adv_n(adv_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
      .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n), .byte_en_n(byte_en_n),
      .kind(kind), .is_wr(is_wr), .illegal(illegal), .lane_mask(lane_mask)
   );

   burst_addr_ctr #(.AW(AW)) u_ctr (
      .clk(clk), .rst_n(rst_n),
      .load(kind == K_BEGIN), .step(kind == K_CONT),
      .order_ilv(order_ilv), .addr_i(addr_i), .addr_o(addr_o)
   );

   assign moves = (kind == K_BEGIN) || (kind == K_CONT) || (kind == K_HOLD);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_q  <= CMD_IDLE;
         mask_q <= '0;
         live_q <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         err_q  <= illegal;
         cmd_q  <= moves ? (is_wr ? CMD_WRITE : CMD_READ) : CMD_IDLE;
         mask_q <= (moves && is_wr) ? lane_mask : '0;
         if (kind == K_BEGIN)      live_q <= 1'b1;
         else if (kind == K_DESEL) live_q <= 1'b0;
      end
   end

   assign cmd_o     = cmd_q;
   assign wr_mask_o = mask_q;
   assign active_o  = live_q;
   assign err_o     = err_q;

   // R9: a sleeping cycle produces an idle command
   p_sleep_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      asleep |=> (cmd_o == CMD_IDLE));
   // R10: a refused write is never issued
   p_refused_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> (cmd_o == CMD_IDLE));
   // R5: mask bits only accompany a write
   p_mask_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_o != CMD_WRITE) |-> (wr_mask_o == '0));
   // R8: an idle that is not a refusal closes the burst
   p_idle_closes_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_o == CMD_IDLE && !err_o) |-> !active_o);
endmodule

// File: tb/burst_seq_test.sv
module burst_seq_test;
   localparam int AW = 8;
   localparam int NB = 2;
   localparam int RC = 3;

   logic          clk = 1'b0;
   logic          rst_n, sleep_i, order_ilv;
   logic          ads_proc_n, ads_ctrl_n, adv_n, ce1_n, ce2, ce3_n;
   logic          wr_all_n, wr_byte_n;
   logic [NB-1:0] byte_en_n;
   logic [AW-1:0] addr_i, addr_o;
   logic [1:0]    cmd_o;
   logic [NB-1:0] wr_mask_o;
   logic          active_o, err_o;

   int checks = 0;
   int errors = 0;
   bit done   = 0;

   burst_seq #(.AW(AW), .NB(NB), .RECOV_CYC(RC)) uut (
      .clk(clk), .rst_n(rst_n), .sleep_i(sleep_i), .order_ilv(order_ilv),
      .ads_proc_n(ads_proc_n), .ads_ctrl_n(ads_ctrl_n), .adv_n(adv_n),
      .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .wr_all_n(wr_all_n),
      .wr_byte_n(wr_byte_n), .byte_en_n(byte_en_n), .addr_i(addr_i),
      .addr_o(addr_o), .cmd_o(cmd_o), .wr_mask_o(wr_mask_o),
      .active_o(active_o), .err_o(err_o)
   );

   always #5 clk = ~clk;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic idle_in();
      ads_proc_n = 1'b1; ads_ctrl_n = 1'b1; adv_n = 1'b1;
      ce1_n = 1'b0; ce2 = 1'b1; ce3_n = 1'b0;
      wr_all_n = 1'b1; wr_byte_n = 1'b1; byte_en_n = '1;
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic begin_ctrl(input logic [AW-1:0] a);
      idle_in();
      ads_ctrl_n = 1'b0;
      addr_i = a;
   endtask

   initial begin
      rst_n = 1'b0; sleep_i = 1'b0; order_ilv = 1'b1; addr_i = '0;
      idle_in();
      repeat (3) tick();
      rst_n = 1'b1;
      chk("R11 cmd", 32'(cmd_o), 0);
      chk("R11 active", 32'(active_o), 0);
      chk("R11 err", 32'(err_o), 0);
      chk("R11 mask", 32'(wr_mask_o), 0);

      // R1 R2 R3 R7: every start value in both orders
      for (int ilv = 0; ilv < 2; ilv++) begin
         for (int s = 0; s < 4; s++) begin
            logic [AW-1:0] a0;
            logic [1:0]    lo;
            a0 = AW'(((s + ilv * 4 + 5) << 2) | s);
            order_ilv = 1'(ilv);
            begin_ctrl(a0);
            tick();
            chk("R3 begin addr", 32'(addr_o), 32'(a0));
            chk("R4 begin read", 32'(cmd_o), 1);
            lo = 2'(s);
            for (int i = 1; i < 6; i++) begin
               idle_in(); adv_n = 1'b0; addr_i = ~a0;
               tick();
               lo = ilv ? 2'(s ^ (i % 4)) : 2'((s + i) % 4);
               chk(ilv ? "R2 interleaved" : "R1 linear", 32'(addr_o),
                   32'({a0[AW-1:2], lo}));
               if (i == 4) chk("R3 wrap to start", 32'(addr_o), 32'(a0));
            end
            idle_in();
            tick();
            chk("R7 suspend holds", 32'(addr_o), 32'({a0[AW-1:2], lo}));
            chk("R7 suspend read", 32'(cmd_o), 1);
            idle_in(); ads_ctrl_n = 1'b0; ce1_n = 1'b1;
            tick();
            chk("R8 ce1 deselect cmd", 32'(cmd_o), 0);
            chk("R8 ce1 deselect active", 32'(active_o), 0);
         end
      end

      // R4: processor strobe with every write input low is a read
      order_ilv = 1'b1;
      idle_in(); ads_proc_n = 1'b0; wr_all_n = 1'b0; wr_byte_n = 1'b0;
      byte_en_n = '0; addr_i = 8'h55;
      tick();
      chk("R4 proc cmd", 32'(cmd_o), 1);
      chk("R4 proc mask", 32'(wr_mask_o), 0);
      chk("R4 proc addr", 32'(addr_o), 32'h55);

      // R6: masked processor strobe acts as no strobe -> continue
      idle_in(); ads_proc_n = 1'b0; ce1_n = 1'b1; adv_n = 1'b0; addr_i = 8'hAA;
      tick();
      chk("R6 masked strobe continues", 32'(addr_o), 32'h54);
      chk("R6 masked strobe cmd", 32'(cmd_o), 1);
      chk("R6 burst open", 32'(active_o), 1);

      // R8: enables 2 and 3
      idle_in(); ads_proc_n = 1'b0; ce2 = 1'b0; addr_i = 8'h11;
      tick();
      chk("R8 ce2 low cmd", 32'(cmd_o), 0);
      chk("R8 ce2 low active", 32'(active_o), 0);
      begin_ctrl(8'h12); ce3_n = 1'b1;
      tick();
      chk("R8 ce3 high cmd", 32'(cmd_o), 0);
      idle_in(); adv_n = 1'b0;
      tick();
      chk("R8 no burst idle", 32'(cmd_o), 0);
      chk("R8 no burst addr", 32'(addr_o), 32'h54);

      // R5: full write decode on the controller strobe
      for (int gw = 0; gw < 2; gw++) begin
         for (int bw = 0; bw < 2; bw++) begin
            for (int be = 0; be < 4; be++) begin
               bit            wr;
               logic [NB-1:0] m;
               begin_ctrl(8'h10);
               wr_all_n = 1'(gw); wr_byte_n = 1'(bw); byte_en_n = 2'(be);
               wr = (gw == 0) || (bw == 0 && be != 3);
               m  = (gw == 0) ? 2'b11 : ((bw == 0) ? ~2'(be) : 2'b00);
               tick();
               chk("R5 cmd", 32'(cmd_o), wr ? 2 : 1);
               chk("R5 mask", 32'(wr_mask_o), 32'(m));
            end
         end
      end

      // R7: continue burst with write then read
      order_ilv = 1'b0;
      begin_ctrl(8'h20); wr_byte_n = 1'b0; byte_en_n = 2'b10;
      tick();
      idle_in(); adv_n = 1'b0; wr_byte_n = 1'b0; byte_en_n = 2'b10;
      tick();
      chk("R7 cont write cmd", 32'(cmd_o), 2);
      chk("R7 cont write addr", 32'(addr_o), 32'h21);
      chk("R7 cont write mask", 32'(wr_mask_o), 1);
      idle_in(); adv_n = 1'b0;
      tick();
      chk("R7 cont read cmd", 32'(cmd_o), 1);
      chk("R7 cont read addr", 32'(addr_o), 32'h22);

      // R9: sleep
      begin_ctrl(8'h40);
      tick();
      idle_in(); adv_n = 1'b0; sleep_i = 1'b1;
      tick();
      chk("R9 first edge runs", 32'(addr_o), 32'h41);
      tick();
      chk("R9 second edge runs", 32'(cmd_o), 1);
      chk("R9 second edge addr", 32'(addr_o), 32'h42);
      tick();
      chk("R9 asleep idle", 32'(cmd_o), 0);
      chk("R9 asleep addr", 32'(addr_o), 32'h42);
      begin_ctrl(8'h77); wr_all_n = 1'b0;
      tick();
      chk("R9 ignores begin cmd", 32'(cmd_o), 0);
      chk("R9 ignores begin addr", 32'(addr_o), 32'h42);

      // R10: recovery window
      idle_in(); sleep_i = 1'b0;
      tick();
      begin_ctrl(8'h78);
      tick();
      chk("R9 still asleep", 32'(cmd_o), 0);
      chk("R9 still asleep addr", 32'(addr_o), 32'h42);
      begin_ctrl(8'h30); wr_all_n = 1'b0;
      tick();
      chk("R10 write refused cmd", 32'(cmd_o), 0);
      chk("R10 write refused err", 32'(err_o), 1);
      chk("R10 write refused addr", 32'(addr_o), 32'h42);
      begin_ctrl(8'h31);
      tick();
      chk("R10 read allowed", 32'(cmd_o), 1);
      chk("R10 read addr", 32'(addr_o), 32'h31);
      chk("R10 err clear", 32'(err_o), 0);
      begin_ctrl(8'h32); wr_all_n = 1'b0;
      tick();
      chk("R10 last window write", 32'(err_o), 1);
      chk("R10 last window addr", 32'(addr_o), 32'h31);
      begin_ctrl(8'h33); wr_all_n = 1'b0;
      tick();
      chk("R10 after window write", 32'(cmd_o), 2);
      chk("R10 after window err", 32'(err_o), 0);
      chk("R10 after window mask", 32'(wr_mask_o), 3);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #1000000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule